// File: doc/BRIEF.md
# Gated 13-bit timer/counter

This block is a timer/counter in the classic microcontroller style, fixed in its 13-bit mode. The count sits in two software-writable bytes. The low byte supplies five counting bits. Its upper three bits are storage only. The high byte supplies the other eight counting bits, so the full count is the high byte followed by the five low bits. Each step adds one to that 13-bit value. When the value rolls over from all ones to zero, a sticky overflow flag is raised, and that flag is the interrupt request.

The count source comes from a control byte. It can be falling edges on an external count pin, every system clock, or a prescaled tick supplied from outside. A run bit enables counting. A gate bit adds a second condition: an external level input must also be high. With the gate set, the count measures how long that input stays high, which is how pulse widths are measured. Both external pins pass through two-flop synchronizers before use. Software loads the count bytes before starting the timer, and starting it never clears them.

Top module: `gated_timer13`

## Requirements
- R1: After reset both count bytes, the control bits and the overflow flag are zero.
- R2: A control write stores wrData[0] as run, wrData[1] as gate enable, wrData[2] as pin-count select and wrData[3] as system-clock select, and these read back on ctrlState[3:0]. In the same write, wrData[4] is the value given to the overflow flag.
- R3: With pin-count select 0 and system-clock select 1, the count advances by one on every clock edge while counting is enabled.
- R4: With pin-count select 0 and system-clock select 0, the count advances only on edges where preTick is high.
- R5: With pin-count select 1, the count advances once for each falling edge of cntPin, whatever the system-clock select is. Rising edges are ignored. The step lands on the third rising clock edge after the pin falls.
- R6: Counting is enabled only when run is 1 and either gate enable is 0 or the synchronized gatePin is 1. Otherwise the count holds, and a gated count equals the number of cycles gatePin was high.
- R7: Setting run leaves the loaded count unchanged; counting continues from the loaded value.
- R8: When the five low counting bits step from 31 to 0, the high byte steps by one. Bits 7..5 of the low byte keep their written value while counting.
- R9: A step from 0x1FFF to 0x0000 sets the overflow flag (ovfIrq), which stays set until a control write with bit 4 clear. A wrap in the same cycle as that write leaves the flag set.
- R10: A write to either count byte in a cycle where a step is due loads the written value, and no step happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntPin | input | 1 | External count input, asynchronous |
| gatePin | input | 1 | External gate level, asynchronous |
| preTick | input | 1 | Prescaled count enable, one cycle per tick |
| wrLowEn | input | 1 | Write strobe for the low count byte |
| wrHighEn | input | 1 | Write strobe for the high count byte |
| wrCtrlEn | input | 1 | Write strobe for control bits and the flag |
| wrData | input | 8 | Write data shared by all three write strobes |
| countLow | output | 8 | Low count byte (bits 4..0 count) |
| countHigh | output | 8 | High count byte |
| ctrlState | output | 4 | Control bits: run, gate, pin select, clock select |
| ovfIrq | output | 1 | Sticky overflow flag and interrupt request |

## Verification
The bench loads 0x1FFF and 0x1F in the low field, and checks both the full rollover and the carry into the high byte. If the carry logic were wrong, the high byte would be left stale, or the storage bits 7..5 of the low byte would be corrupted. It writes a count byte in the same cycle as a due step. A design that let the step win would then show the loaded value plus one. It clears the flag with the same write that stops a wrapping count. If the clear won, the flag would be lost. It counts falling pin edges, checks the exact latency of the three-edge delay, and measures a gated pulse. This catches a design that counts both pin edges, gets the synchronizer depth wrong, or ignores the gate.

// File: rtl/timer13_pkg.sv
package timer13_pkg;

  localparam int CTRL_W   = 4;
  localparam int FLAG_BIT = 4;

  // Control register layout, bit 3 down to bit 0.
  typedef struct packed {
    logic sysSel;   // 1: count every system clock (when not pin counting)
    logic pinSel;   // 1: count falling edges of the external pin
    logic gateOn;   // 1: require the gate pin high
    logic runOn;    // 1: timer running
  } ctrlBits_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic countStep;
    logic loadLow;
    logic loadHigh;
    logic flagWrite;
    logic flagValue;
  } strobe_t;

endpackage

// File: rtl/timer13_sync.sv
module timer13_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  generate
    if (STAGES <= 1) begin : g_single
      logic stageQ;
      always_ff @(posedge clk) begin
        if (!rstN) stageQ <= RST_VAL;
        else       stageQ <= din;
      end
      assign dout = stageQ;
    end else begin : g_chain
      logic [STAGES-1:0] chainQ;
      always_ff @(posedge clk) begin
        if (!rstN) chainQ <= {STAGES{RST_VAL}};
        else       chainQ <= {chainQ[STAGES-2:0], din};
      end
      assign dout = chainQ[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/timer13_ctrl.sv
module timer13_ctrl
  import timer13_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntPin,
  input  logic              gatePin,
  input  logic              preTick,
  input  logic              wrLowEn,
  input  logic              wrHighEn,
  input  logic              wrCtrlEn,
  input  logic [CTRL_W:0]   ctrlData,
  output ctrlBits_t         ctrlQ,
  output strobe_t           stb
);

  logic pinSync;
  logic gateSync;
  logic pinPrev;
  logic fallSeen;
  logic srcTick;
  logic runGate;

  timer13_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pinSync (
    .clk (clk), .rstN(rstN), .din(cntPin), .dout(pinSync)
  );

  timer13_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_gateSync (
    .clk (clk), .rstN(rstN), .din(gatePin), .dout(gateSync)
  );

  always_ff @(posedge clk) begin
    if (!rstN) pinPrev <= 1'b0;
    else       pinPrev <= pinSync;
  end

  // Falling edge: was high last cycle, low now.
  assign fallSeen = pinPrev & ~pinSync;

  always_ff @(posedge clk) begin
    if (!rstN)         ctrlQ <= '0;
    else if (wrCtrlEn) ctrlQ <= ctrlBits_t'(ctrlData[CTRL_W-1:0]);
  end

  always_comb begin
    if (ctrlQ.pinSel)      srcTick = fallSeen;
    else if (ctrlQ.sysSel) srcTick = 1'b1;
    else                   srcTick = preTick;
  end

  assign runGate = ctrlQ.runOn & (~ctrlQ.gateOn | gateSync);

  always_comb begin
    stb.loadLow   = wrLowEn;
    stb.loadHigh  = wrHighEn;
    // A count-register write suppresses the step in that cycle.
    stb.countStep = runGate & srcTick & ~wrLowEn & ~wrHighEn;
    stb.flagWrite = wrCtrlEn;
    stb.flagValue = ctrlData[FLAG_BIT];
  end

endmodule

// File: rtl/timer13_datapath.sv
module timer13_datapath
  import timer13_pkg::*;
#(
  parameter int LOW_W  = 5,
  parameter int HIGH_W = 8,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  lowQ,
  output logic [HIGH_W-1:0] highQ,
  output logic              flagQ
);

  logic [LOW_W-1:0]  lowField;
  logic [LOW_W-1:0]  lowFieldInc;
  logic [HIGH_W-1:0] highInc;
  logic              lowFull;
  logic              highFull;
  logic              wrapEvt;

  assign lowField    = lowQ[LOW_W-1:0];
  assign lowFieldInc = lowField + 1'b1;
  assign highInc     = highQ + 1'b1;
  assign lowFull     = &lowField;
  assign highFull    = &highQ;
  assign wrapEvt     = stb.countStep & lowFull & highFull;

  always_ff @(posedge clk) begin
    if (!rstN)              lowQ <= '0;
    else if (stb.loadLow)   lowQ <= wrData;
    else if (stb.countStep) lowQ[LOW_W-1:0] <= lowFieldInc;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                         highQ <= '0;
    else if (stb.loadHigh)             highQ <= wrData[HIGH_W-1:0];
    else if (stb.countStep && lowFull) highQ <= highInc;
  end

  // Wrap sets the flag and wins over a software write in the same cycle.
  always_ff @(posedge clk) begin
    if (!rstN)              flagQ <= 1'b0;
    else if (wrapEvt)       flagQ <= 1'b1;
    else if (stb.flagWrite) flagQ <= stb.flagValue;
  end

endmodule

// File: rtl/gated_timer13.sv
module gated_timer13
  import timer13_pkg::*;
#(
  parameter int LOW_W       = 5,
  parameter int HIGH_W      = 8,
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntPin,
  input  logic              gatePin,
  input  logic              preTick,
  input  logic              wrLowEn,
  input  logic              wrHighEn,
  input  logic              wrCtrlEn,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  countLow,
  output logic [HIGH_W-1:0] countHigh,
  output logic [CTRL_W-1:0] ctrlState,
  output logic              ovfIrq
);

  ctrlBits_t ctrlQ;
  strobe_t   stb;

  timer13_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cntPin   (cntPin),
    .gatePin  (gatePin),
    .preTick  (preTick),
    .wrLowEn  (wrLowEn),
    .wrHighEn (wrHighEn),
    .wrCtrlEn (wrCtrlEn),
    .ctrlData (wrData[CTRL_W:0]),
    .ctrlQ    (ctrlQ),
    .stb      (stb)
  );

  timer13_datapath #(.LOW_W(LOW_W), .HIGH_W(HIGH_W), .REG_W(REG_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (wrData),
    .lowQ   (countLow),
    .highQ  (countHigh),
    .flagQ  (ovfIrq)
  );

  assign ctrlState = ctrlQ;

endmodule

// File: rtl/gated_timer13_chk.sv
module gated_timer13_chk #(
  parameter int LOW_W  = 5,
  parameter int HIGH_W = 8,
  parameter int REG_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrLowEn,
  input logic              wrHighEn,
  input logic              wrCtrlEn,
  input logic [REG_W-1:0]  wrData,
  input logic [REG_W-1:0]  countLow,
  input logic [HIGH_W-1:0] countHigh,
  input logic [3:0]        ctrlState,
  input logic              ovfIrq
);

  localparam int CNT_W = LOW_W + HIGH_W;

  logic [CNT_W-1:0] cnt;
  logic             noLoad;
  assign cnt    = {countHigh, countLow[LOW_W-1:0]};
  assign noLoad = !wrLowEn && !wrHighEn;

  // R2
  ctrl_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrlEn |=> ctrlState == $past(wrData[3:0]));

  // R3
  sys_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == 4'b1001 && noLoad) |=> cnt == $past(cnt) + 1'b1);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlState[0] && noLoad) |=> $stable(cnt));

  // R8
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrLowEn |=> $stable(countLow[REG_W-1:LOW_W]));

  // R9
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == 4'b1001 && noLoad && cnt == {CNT_W{1'b1}}) |=> ovfIrq);

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfIrq && !wrCtrlEn) |=> ovfIrq);

  // R10
  low_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrLowEn |=> countLow == $past(wrData));

  // R10
  high_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrHighEn |=> countHigh == $past(wrData[HIGH_W-1:0]));

endmodule

bind gated_timer13 gated_timer13_chk #(
  .LOW_W(LOW_W), .HIGH_W(HIGH_W), .REG_W(REG_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrLowEn   (wrLowEn),
  .wrHighEn  (wrHighEn),
  .wrCtrlEn  (wrCtrlEn),
  .wrData    (wrData),
  .countLow  (countLow),
  .countHigh (countHigh),
  .ctrlState (ctrlState),
  .ovfIrq    (ovfIrq)
);

// File: tb/gated_timer13_tb.sv
`timescale 1ns/1ps
module gated_timer13_tb;

  localparam int RUN  = 1;
  localparam int GATE = 2;
  localparam int PIN  = 4;
  localparam int SYS  = 8;

  // field codes: 0 count13, 1 low byte, 2 high byte, 3 irq, 4 ctrl
  typedef struct {
    string req;
    int    field;
    int    expv;
  } item_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cntPin = 1'b1;
  logic       gatePin = 1'b0;
  logic       preTick = 1'b0;
  logic       wrLowEn = 1'b0;
  logic       wrHighEn = 1'b0;
  logic       wrCtrlEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] countLow;
  logic [7:0] countHigh;
  logic [3:0] ctrlState;
  logic       ovfIrq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  item_t sbq[$];

  always #2 clk = ~clk;

  gated_timer13 u_dut (
    .clk(clk), .rstN(rstN), .cntPin(cntPin), .gatePin(gatePin),
    .preTick(preTick), .wrLowEn(wrLowEn), .wrHighEn(wrHighEn),
    .wrCtrlEn(wrCtrlEn), .wrData(wrData), .countLow(countLow),
    .countHigh(countHigh), .ctrlState(ctrlState), .ovfIrq(ovfIrq)
  );

  function automatic int observe(int field);
    case (field)
      0: return int'({countHigh, countLow[4:0]});
      1: return int'(countLow);
      2: return int'(countHigh);
      3: return int'(ovfIrq);
      default: return int'(ctrlState);
    endcase
  endfunction

  // Monitor: compares queued expectations just after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sbq.size() > 0) begin
        item_t it;
        int act;
        it = sbq.pop_front();
        act = observe(it.field);
        checks++;
        if (act != it.expv) begin
          failures++;
          $display("FAIL %s field=%0d actual=0x%0h expected=0x%0h",
                   it.req, it.field, act, it.expv);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_val(input string req, input int field, input int v);
    item_t it;
    it.req = req; it.field = field; it.expv = v;
    sbq.push_back(it);
  endtask

  task automatic wr_low(input int v);
    wrData = 8'(v); wrLowEn = 1'b1; cyc(1); wrLowEn = 1'b0;
  endtask

  task automatic wr_high(input int v);
    wrData = 8'(v); wrHighEn = 1'b1; cyc(1); wrHighEn = 1'b0;
  endtask

  task automatic wr_ctrl(input int v);
    wrData = 8'(v); wrCtrlEn = 1'b1; cyc(1); wrCtrlEn = 1'b0;
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R1 reset state
    expect_val("R1", 0, 0);
    expect_val("R1", 1, 0);
    expect_val("R1", 3, 0);
    expect_val("R1", 4, 0);

    // R2 register writes and control readback
    wr_low(8'hA7); wr_high(8'h3C);
    expect_val("R2", 1, 8'hA7);
    expect_val("R2", 2, 8'h3C);
    wr_ctrl(SYS | GATE);
    expect_val("R2", 4, 4'hA);

    // R7 start keeps the loaded value; R3 system clock rate (idle K gives K+1)
    wr_low(8'h03); wr_high(8'h09);
    wr_ctrl(SYS | RUN); cyc(4); wr_ctrl(SYS);
    expect_val("R7", 0, 296);
    wr_ctrl(SYS | RUN); cyc(20); wr_ctrl(SYS);
    expect_val("R3", 0, 317);

    // R8 carry into the high byte
    wr_low(8'h1F); wr_high(8'h05);
    wr_ctrl(SYS | RUN); wr_ctrl(SYS);
    expect_val("R8", 1, 8'h00);
    expect_val("R8", 2, 8'h06);
    // R8 upper low bits preserved across the low-field wrap
    wr_low(8'hBE); wr_high(8'h02);
    wr_ctrl(SYS | RUN); cyc(1); wr_ctrl(SYS);
    expect_val("R8", 1, 8'hA0);
    expect_val("R8", 2, 8'h03);

    // R9 full wrap, set wins over the clearing write in the same cycle
    wr_low(8'h1F); wr_high(8'hFF);
    wr_ctrl(SYS | RUN); wr_ctrl(SYS);
    expect_val("R9", 0, 0);
    expect_val("R9", 3, 1);
    wr_low(8'h05); cyc(10);
    expect_val("R9 sticky", 3, 1);
    wr_ctrl(SYS);
    expect_val("R9 clear", 3, 0);

    // R10 low write beats the step (wrData 0x08 doubles as ctrl SYS, run off)
    wr_low(0); wr_high(0);
    wr_ctrl(SYS | RUN);
    wrData = 8'h08; wrLowEn = 1'b1; wrCtrlEn = 1'b1; cyc(1);
    wrLowEn = 1'b0; wrCtrlEn = 1'b0;
    expect_val("R10", 0, 8);
    // R10 high write beats the carry
    wr_low(8'h1F); wr_high(8'h10);
    wr_ctrl(SYS | RUN);
    wrData = 8'h08; wrHighEn = 1'b1; wrCtrlEn = 1'b1; cyc(1);
    wrHighEn = 1'b0; wrCtrlEn = 1'b0;
    expect_val("R10", 1, 8'h1F);
    expect_val("R10", 2, 8'h08);

    // R4 prescaled ticks
    wr_low(0); wr_high(0);
    wr_ctrl(RUN);
    for (int i = 0; i < 12; i++) begin
      preTick = (i % 3 == 0);
      cyc(1);
    end
    preTick = 1'b0;
    wr_ctrl(0);
    expect_val("R4", 0, 4);
    wr_ctrl(RUN);
    preTick = 1'b1; cyc(5); preTick = 1'b0;
    wr_ctrl(0);
    expect_val("R4", 0, 9);

    // R5 falling pin edges only, system-clock select ignored
    wr_low(0); wr_high(0);
    wr_ctrl(PIN | SYS | RUN);
    for (int i = 0; i < 5; i++) begin
      cntPin = 1'b0; cyc(4); cntPin = 1'b1; cyc(4);
    end
    cyc(6);
    expect_val("R5", 0, 5);
    cntPin = 1'b0; cyc(2);
    expect_val("R5 latency", 0, 5);
    cyc(1);
    expect_val("R5 latency", 0, 6);
    cntPin = 1'b1; cyc(6);
    wr_ctrl(PIN);
    expect_val("R5", 0, 6);

    // R6 gate blocks, then measures a 7-cycle pulse
    wr_low(0); wr_high(0);
    gatePin = 1'b0;
    wr_ctrl(SYS | GATE | RUN); cyc(10);
    expect_val("R6 gate low", 0, 0);
    gatePin = 1'b1; cyc(7); gatePin = 1'b0; cyc(5);
    expect_val("R6 pulse", 0, 7);
    wr_ctrl(SYS | GATE);
    gatePin = 1'b1; cyc(8);
    expect_val("R6 run off", 0, 7);
    gatePin = 1'b0;

    cyc(3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule